// File: doc/BRIEF.md
# Prioritising Interrupt Controller

This block gathers interrupt requests from up to eight sources, orders them by a fixed priority and raises one interrupt line toward a processor. Each request input is brought into the block clock domain and captured on its rising edge. Captured requests wait in a request register until they can be forwarded. A per-input mask holds any request back without discarding it.

When the processor acknowledges, the controller picks the winning input and moves its bit from the request register to the in-service register. One cycle later it presents a vector equal to the programmed base plus the input number. That input and every input of lower priority stay blocked until software writes an end-of-interrupt command, which releases the highest-priority input still in service.

Software drives the block through a byte-wide write port with two addresses, even and odd. A start command on the even address opens a fixed sequence of three odd-address words: vector base, cascade word, mode word. The block stores the cascade and mode words and shows them on outputs for the surrounding logic. Once configured, odd-address writes load the mask and even-address writes carry the end-of-interrupt command. The read port returns the mask at the odd address and the in-service bits at the even address.

Top module: `pic_top`

## Requirements
- R1: A write of 0x11 to the even address (bus_addr_i = 0) starts initialisation. It clears the mask to 0x00 and clears every request and in-service bit. irq_o stays low until the third odd-address word of the sequence is written. Odd-address writes made before the first initialisation leave the mask unchanged.
- R2: During initialisation, the odd-address words are taken strictly in this order: vector base, cascade word, mode word. After the mode word, cfg_casc_o and cfg_mode_o hold the second and third of these words.
- R3: Once configured, an odd-address write loads the mask, and a 1 in bit i disables input i. bus_rdata_o returns the mask when bus_addr_i = 1 and the in-service bits when bus_addr_i = 0.
- R4: A rising edge on req_i[i] sets request bit i within four clock cycles. A level held high after its edge sets nothing more.
- R5: Priority is fixed, with input 0 highest. irq_o is high exactly when the block is configured and some unmasked pending input has a lower index than every in-service input.
- R6: An ack_i pulse while irq_o is high sets vec_valid_o in the next cycle, with vector_o equal to the base plus the lowest-index unmasked pending input (modulo 256). That input's request bit clears and its in-service bit sets.
- R7: An ack_i pulse while irq_o is low leaves vec_valid_o low and leaves the request and in-service bits unchanged.
- R8: After configuration, a write of 0x20 to the even address clears the lowest-index set in-service bit.
- R9: After reset, irq_o is low, vec_valid_o is low, the mask reads 0xFF, the in-service bits read 0 and the block is unconfigured.
- R10: A masked request stays pending and is forwarded as soon as its mask bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per word |
| bus_addr_i | input | 1 | Port select: 0 is the even address, 1 is the odd address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Mask (odd address) or in-service bits (even address) |
| req_i | input | 8 | Asynchronous request inputs, active on the rising edge |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| vec_valid_o | output | 1 | One-cycle pulse: vector_o is valid |
| vector_o | output | 8 | Vector of the acknowledged input |
| cfg_casc_o | output | 8 | Stored cascade word |
| cfg_mode_o | output | 8 | Stored mode word |

## Verification
The bench builds the block with its default parameters: eight inputs, a two-stage synchroniser, 0x11 as the start command and 0x20 as the end-of-interrupt command. With these values, all eight priority levels and the full mask byte can be reached. The worst-case delay from a request edge to irq_o is short enough for each check to wait a fixed number of cycles. The directed part programs two vector bases (0x20 and 0x28) and both forms of the cascade word. It also covers nested service, acknowledge with no interrupt pending, masking and unmasking, and a level held high. A random mix of request edges, acknowledges, end-of-interrupt writes and mask writes then exercises the priority and service rules under arbitrary combinations of pending, masked and in-service bits.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
   typedef enum logic [1:0] {
      CFG_IDLE = 2'd0,
      CFG_BASE = 2'd1,
      CFG_CASC = 2'd2,
      CFG_MODE = 2'd3
   } cfg_state_t;
endpackage

// File: rtl/pic_cfg.sv
`timescale 1ns/1ps
module pic_cfg
   import pic_pkg::*;
#(
   parameter int         DATA_W   = 8,
   parameter int         NUM_IN   = 8,
   parameter logic [7:0] INIT_CMD = 8'h11,
   parameter logic [7:0] EOI_CMD  = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              configured_o,
   output logic [NUM_IN-1:0] mask_o,
   output logic [DATA_W-1:0] base_o,
   output logic [DATA_W-1:0] casc_o,
   output logic [DATA_W-1:0] mode_o,
   output logic              eoi_o,
   output logic              init_o
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("pic_cfg: DATA_W must be 8");
      end
      if (INIT_CMD == EOI_CMD) begin : g_bad_cmd
         $error("pic_cfg: start and end-of-interrupt commands must differ");
      end
   endgenerate

   cfg_state_t state_q;
   logic       wr_even, wr_odd;

   always_comb begin
      wr_even = wr_i && !addr_i;
      wr_odd  = wr_i && addr_i;
      init_o  = wr_even && (wdata_i == INIT_CMD);
      eoi_o   = wr_even && (wdata_i == EOI_CMD) && configured_o && (state_q == CFG_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= CFG_IDLE;
         configured_o <= 1'b0;
         mask_o       <= '1;
         base_o       <= '0;
         casc_o       <= '0;
         mode_o       <= '0;
      end else if (init_o) begin
         state_q      <= CFG_BASE;
         configured_o <= 1'b0;
         mask_o       <= '0;
      end else if (wr_odd) begin
         unique case (state_q)
            CFG_BASE: begin
               base_o  <= wdata_i;
               state_q <= CFG_CASC;
            end
            CFG_CASC: begin
               casc_o  <= wdata_i;
               state_q <= CFG_MODE;
            end
            CFG_MODE: begin
               mode_o       <= wdata_i;
               state_q      <= CFG_IDLE;
               configured_o <= 1'b1;
            end
            default: begin
               if (configured_o) mask_o <= wdata_i[NUM_IN-1:0];
            end
         endcase
      end
   end

   p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_odd && configured_o && state_q == CFG_IDLE) |=> (mask_o == $past(wdata_i[NUM_IN-1:0])));
   p_seq_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_odd && state_q == CFG_MODE && !init_o) |=> (configured_o && mode_o == $past(wdata_i)));
   p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      init_o |=> (!configured_o && mask_o == '0));
endmodule

// File: rtl/pic_req.sv
`timescale 1ns/1ps
module pic_req #(
   parameter int NUM_IN      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] req_i,
   input  logic              clr_all_i,
   input  logic [NUM_IN-1:0] clr_i,
   output logic [NUM_IN-1:0] irr_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pic_req: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0][NUM_IN-1:0] sync_q;
   logic [NUM_IN-1:0]                  prev_q, rise;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= '0;
               else        sync_q[s] <= req_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= '0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irr_o <= '0;
      else if (clr_all_i) irr_o <= '0;
      else                irr_o <= (irr_o & ~clr_i) | rise;
   end

   p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise & ~clr_i) && !clr_all_i) |=> ((irr_o & $past(rise)) == $past(rise)));
   p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise == '0) |=> ((irr_o & ~$past(irr_o)) == '0));
endmodule

// File: rtl/pic_prio.sv
`timescale 1ns/1ps
module pic_prio #(
   parameter int NUM_IN = 8,
   parameter int IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic [NUM_IN-1:0] pend_i,
   input  logic [NUM_IN-1:0] isr_i,
   output logic              win_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [NUM_IN-1:0] onehot_o
);
   logic [NUM_IN-1:0] svc_at_or_above, allow;

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_block
         if (i == 0) begin : g_top
            assign svc_at_or_above[i] = isr_i[i];
         end else begin : g_rest
            assign svc_at_or_above[i] = svc_at_or_above[i-1] | isr_i[i];
         end
         assign allow[i] = pend_i[i] & ~svc_at_or_above[i];
      end
   endgenerate

   always_comb begin
      idx_o    = '0;
      onehot_o = '0;
      for (int i = NUM_IN - 1; i >= 0; i--) begin
         if (allow[i]) begin
            idx_o    = IDX_W'(i);
            onehot_o = '0;
            onehot_o[i] = 1'b1;
         end
      end
      win_o = |allow;
   end

   always_comb begin
      assert (!win_o || ((onehot_o & pend_i) == onehot_o && $onehot(onehot_o)))
         else $error("p_win_valid_r5: selected input not pending");
   end
endmodule

// File: rtl/pic_top.sv
`timescale 1ns/1ps
module pic_top #(
   parameter int         NUM_IN      = 8,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] INIT_CMD    = 8'h11,
   parameter logic [7:0] EOI_CMD     = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_i,
   input  logic              bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic [NUM_IN-1:0] req_i,
   output logic              irq_o,
   input  logic              ack_i,
   output logic              vec_valid_o,
   output logic [DATA_W-1:0] vector_o,
   output logic [DATA_W-1:0] cfg_casc_o,
   output logic [DATA_W-1:0] cfg_mode_o
);
   localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

   generate
      if (NUM_IN < 1 || NUM_IN > DATA_W) begin : g_bad_inputs
         $error("pic_top: NUM_IN must be between 1 and DATA_W");
      end
   endgenerate

   logic              configured, eoi, init;
   logic [NUM_IN-1:0] mask, irr, isr_q, pend, win_oh, eoi_oh, ack_oh;
   logic [DATA_W-1:0] base;
   logic              win, take;
   logic [IDX_W-1:0]  win_idx;

   pic_cfg #(.DATA_W(DATA_W), .NUM_IN(NUM_IN), .INIT_CMD(INIT_CMD), .EOI_CMD(EOI_CMD)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
      .configured_o(configured), .mask_o(mask), .base_o(base), .casc_o(cfg_casc_o),
      .mode_o(cfg_mode_o), .eoi_o(eoi), .init_o(init)
   );

   pic_req #(.NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES)) u_req (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_all_i(init), .clr_i(ack_oh), .irr_o(irr)
   );

   assign pend = irr & ~mask;

   pic_prio #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_prio (
      .pend_i(pend), .isr_i(isr_q), .win_o(win), .idx_o(win_idx), .onehot_o(win_oh)
   );

   assign irq_o  = configured && win;
   assign take   = ack_i && irq_o;
   assign ack_oh = take ? win_oh : '0;

   always_comb begin
      eoi_oh = '0;
      for (int i = NUM_IN - 1; i >= 0; i--) begin
         if (isr_q[i]) begin
            eoi_oh    = '0;
            eoi_oh[i] = 1'b1;
         end
      end
      if (!eoi) eoi_oh = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    isr_q <= '0;
      else if (init) isr_q <= '0;
      else           isr_q <= (isr_q & ~eoi_oh) | ack_oh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid_o <= 1'b0;
         vector_o    <= '0;
      end else begin
         vec_valid_o <= take;
         if (take) vector_o <= base + DATA_W'(win_idx);
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i) bus_rdata_o[NUM_IN-1:0] = mask;
      else            bus_rdata_o[NUM_IN-1:0] = isr_q;
   end

   p_quiet_unconfig_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !configured |-> !irq_o);
   p_ack_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> vec_valid_o);
   p_ack_isr_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && !eoi && !init) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));
   p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_i && irq_o) |=> !vec_valid_o);
   p_idle_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !irq_o && !eoi && !init) |=> $stable(isr_q));
   p_eoi_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr_q != '0 && !take) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
   p_irq_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend != '0));
endmodule

// File: tb/pic_top_test.sv
`timescale 1ns/1ps
module pic_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr_i = 1'b0;
   logic       bus_addr_i = 1'b0;
   logic [7:0] bus_wdata_i = '0;
   logic [7:0] bus_rdata_o;
   logic [7:0] req_i = '0;
   logic       irq_o;
   logic       ack_i = 1'b0;
   logic       vec_valid_o;
   logic [7:0] vector_o, cfg_casc_o, cfg_mode_o;

   int n_chk = 0;
   int n_bad = 0;

   // bench model state
   logic [7:0] m_irr = '0, m_isr = '0, m_mask = 8'hFF, m_base = '0;
   logic       m_cfg = 1'b0;
   int         m_step = 0;

   always #4 clk = ~clk;

   pic_top uut (
      .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .req_i(req_i), .irq_o(irq_o),
      .ack_i(ack_i), .vec_valid_o(vec_valid_o), .vector_o(vector_o),
      .cfg_casc_o(cfg_casc_o), .cfg_mode_o(cfg_mode_o)
   );

   function automatic int low_idx(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   function automatic logic exp_irq();
      logic [7:0] p = m_irr & ~m_mask;
      return m_cfg && (p != 0) && (low_idx(p) < low_idx(m_isr));
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_wr_i = 1'b0; bus_addr_i = 1'b0;
      if (!a && d == 8'h11) begin
         m_step = 1; m_cfg = 0; m_mask = '0; m_irr = '0; m_isr = '0;
      end else if (!a && d == 8'h20 && m_cfg && m_step == 0) begin
         if (m_isr != 0) m_isr[low_idx(m_isr)] = 1'b0;
      end else if (a) begin
         case (m_step)
            1: begin m_base = d; m_step = 2; end
            2: m_step = 3;
            3: begin m_step = 0; m_cfg = 1; end
            default: if (m_cfg) m_mask = d;
         endcase
      end
   endtask

   task automatic read_check(input string req);
      bus_addr_i = 1'b1; #1;
      chk(req, "mask readback", bus_rdata_o, m_mask);
      bus_addr_i = 1'b0; #1;
      chk(req, "in-service readback", bus_rdata_o, m_isr);
   endtask

   task automatic raise(input int i);
      @(negedge clk);
      if (!req_i[i]) m_irr[i] = 1'b1;
      req_i[i] = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic lower(input int i);
      @(negedge clk);
      req_i[i] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse(input int i);
      raise(i);
      lower(i);
   endtask

   task automatic ack(input string req);
      logic       e = exp_irq();
      logic [7:0] p = m_irr & ~m_mask;
      logic [7:0] ev = '0;
      @(negedge clk);
      ack_i = 1'b1;
      if (e) begin
         ev = m_base + 8'(low_idx(p));
         m_isr[low_idx(p)] = 1'b1;
         m_irr[low_idx(p)] = 1'b0;
      end
      @(negedge clk);
      ack_i = 1'b0;
      chk(req, "vec_valid", vec_valid_o, e);
      if (e) chk(req, "vector", vector_o, ev);
   endtask

   task automatic irq_check(input string req);
      #1 chk(req, "irq", irq_o, exp_irq());
   endtask

   task automatic init_seq(input logic [7:0] b, input logic [7:0] c, input logic [7:0] md);
      wr(1'b0, 8'h11);
      irq_check("R1");
      wr(1'b1, b);
      irq_check("R1");
      wr(1'b1, c);
      irq_check("R1");
      wr(1'b1, md);
      chk("R2", "cascade word", cfg_casc_o, c);
      chk("R2", "mode word", cfg_mode_o, md);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9", "irq after reset", irq_o, 0);
      chk("R9", "vec_valid after reset", vec_valid_o, 0);
      read_check("R9");
      // R1 odd write before any init is ignored; unconfigured block stays quiet
      wr(1'b1, 8'h00);
      read_check("R1");
      pulse(0);
      irq_check("R1");
      // R1 / R2 initialisation as master, cascade on input 2
      init_seq(8'h20, 8'h04, 8'h01);
      read_check("R1");
      irq_check("R1");
      // R5 / R6 priority and nesting
      pulse(5);
      pulse(2);
      irq_check("R5");
      ack("R6");
      read_check("R6");
      irq_check("R5");
      ack("R7");
      read_check("R7");
      pulse(1);
      irq_check("R5");
      ack("R6");
      wr(1'b0, 8'h20);
      read_check("R8");
      irq_check("R8");
      wr(1'b0, 8'h20);
      read_check("R8");
      irq_check("R5");
      ack("R6");
      wr(1'b0, 8'h20);
      read_check("R8");
      // R10 / R3 masking
      wr(1'b1, 8'h08);
      read_check("R3");
      pulse(3);
      irq_check("R10");
      wr(1'b1, 8'h00);
      irq_check("R10");
      ack("R10");
      wr(1'b0, 8'h20);
      // R4 level held produces one request only
      raise(6);
      irq_check("R4");
      ack("R4");
      wr(1'b0, 8'h20);
      repeat (6) @(negedge clk);
      irq_check("R4");
      lower(6);
      irq_check("R4");
      // R2 reinit as secondary with identity 2 and base 0x28
      init_seq(8'h28, 8'h02, 8'h01);
      pulse(7);
      irq_check("R5");
      ack("R6");
      wr(1'b0, 8'h20);
      // random mix
      for (int k = 0; k < 400; k++) begin
         int op = $urandom % 5;
         case (op)
            0, 1: pulse($urandom % 8);
            2: ack("R6");
            3: wr(1'b0, 8'h20);
            default: wr(1'b1, 8'($urandom) & 8'($urandom));
         endcase
         irq_check("R5");
         read_check("R3");
      end
      summary();
   end
endmodule